// File: doc/BRIEF.md
# Burst-Counted SPI Read Master

This block drives one SPI burst framed by a single chip-select window. Software loads a byte count for the whole burst and a second, smaller count for the leading bytes that come from the transmit FIFO. It then sets the start bit. The engine shifts out those queued bytes. After that it keeps clocking filler bytes until the whole burst has been exchanged. Every byte that arrives on the input line goes into the receive FIFO, including the bytes that come back while the command prefix is still being sent.

A typical use is a flash read. The host queues a one-byte opcode and a three-byte address, sets the transmit count to 4 and the total count to 4 plus the payload length. When the start bit reads back as 0, the host discards the first four receive entries and drains the rest. The serial side runs in mode 0: SCK idles low, MOSI changes on falling SCK, MISO is sampled on rising SCK, and each byte goes out MSB first. The SCK half-period is a programmable number of module clocks.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, chip select is high and SCK is low. The control word and the status word read 0, and the half-period register reads 1 (SCK = module clock / 4).
- R2: Control word bits are enable = bit 0, master = bit 1, TX FIFO clear = bit 8, RX FIFO clear = bit 9 and start = bit 10. Enable and master read back as written. Both clear bits read 0 and empty their FIFO on the cycle they are written.
- R3: Writing the control word with bit 10 set starts a burst only if bits 0 and 1 are set in the same write, the total count is non-zero and no burst is running. Otherwise the start request is ignored: chip select stays high and bit 10 reads 0.
- R4: Bit 10 of the control word reads 1 from the cycle after a burst starts until chip select returns high, and then clears itself.
- R5: A burst exchanges exactly TOTAL bytes (register 1). Byte i (counted from 0) is the next TX FIFO entry if i < SEND (register 2) and the TX FIFO is not empty. In every other case it is the filler 0x00, and no TX entry is consumed.
- R6: Every received byte of the burst is written to the RX FIFO in arrival order. This includes the bytes received during the transmit prefix. A read of register 5 returns the oldest entry and removes it.
- R7: Status register 3 holds the RX FIFO level in bits [6:0], the TX FIFO level in bits [14:8], the RX overflow flag in bit 16 and burst activity in bit 17. Each FIFO holds 64 bytes.
- R8: A byte that arrives while the RX FIFO holds 64 entries is dropped and sets the overflow flag. The flag stays set until an RX FIFO clear.
- R9: Mode 0, MSB first: MOSI changes only while SCK is low, and the slave sees each transmitted byte starting with bit 7.
- R10: Each SCK half-period lasts HALF+1 module clocks, where HALF is register 6. An SCK period is 2*(HALF+1) clocks.
- R11: Chip select falls HALF+1 clocks before the first rising SCK edge. It rises HALF+1 clocks after the last falling edge. SCK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the RX FIFO at register 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The checker assumes three things about the inputs. Register strobes are single-cycle pulses sampled on the rising clock. MISO changes only on the module clock. The RX FIFO clear is the only way the overflow flag may drop. The bench respects all three. Its slave model updates MISO only after it sees a falling SCK, and it captures MOSI only on a rising SCK. Register accesses are issued away from the active edge. Random bursts vary the half-period, the total and transmit counts and how many TX bytes are queued, including fewer than the transmit count. Directed cases cover ignored starts, FIFO clears and an RX overflow.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    // control word bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_MST   = 1;
    localparam int CTL_TXCLR = 8;
    localparam int CTL_RXCLR = 9;
    localparam int CTL_GO    = 10;

    // status word field positions
    localparam int STS_RXLVL = 0;
    localparam int STS_TXLVL = 8;
    localparam int STS_OVF   = 16;
    localparam int STS_BUSY  = 17;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_TOTAL = 3'd1,
        RA_SEND  = 3'd2,
        RA_STAT  = 3'd3,
        RA_TXPSH = 3'd4,
        RA_RXPOP = 3'd5,
        RA_HALF  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH,
        ENG_TRAIL
    } eng_state_e;

    typedef struct packed {
        logic go;
        logic rx_clr;
        logic tx_clr;
        logic master;
        logic enable;
    } ctrl_req_t;

    function automatic ctrl_req_t decode_ctrl(input logic [31:0] w);
        ctrl_req_t c;
        c.go     = w[CTL_GO];
        c.rx_clr = w[CTL_RXCLR];
        c.tx_clr = w[CTL_TXCLR];
        c.master = w[CTL_MST];
        c.enable = w[CTL_EN];
        return c;
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_burst_pkg::*;
#(
    parameter int         CNT_W  = 12,
    parameter int         HALF_W = 8,
    parameter logic [7:0] FILL   = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  total,
    input  logic [CNT_W-1:0]  send,
    input  logic [HALF_W-1:0] half,
    input  logic              tx_empty,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [7:0]        rx_data,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    eng_state_e        state;
    logic [HALF_W-1:0] tmr, half_q;
    logic [2:0]        bit_idx;
    logic [CNT_W-1:0]  byte_idx, tot_q, send_q;
    logic [7:0]        tx_sh, rx_sh;

    logic              tick, last_byte, load_now;
    logic [CNT_W-1:0]  load_idx, send_lim;
    logic [7:0]        load_val;

    assign tick      = (tmr == '0);
    assign last_byte = (byte_idx == tot_q - 1'b1);
    assign busy      = (state != ENG_IDLE);
    assign mosi      = tx_sh[7];

    // next outgoing byte: from the queue while inside the send window
    always_comb begin
        load_now = 1'b0;
        load_idx = '0;
        send_lim = send_q;
        if (state == ENG_IDLE) begin
            send_lim = send;
            load_now = start;
        end else if (state == ENG_HIGH && tick && bit_idx == 3'd7 && !last_byte) begin
            load_now = 1'b1;
            load_idx = byte_idx + 1'b1;
        end
    end

    assign tx_pop   = load_now && (load_idx < send_lim) && !tx_empty;
    assign load_val = tx_pop ? tx_data : FILL;

    // a byte is complete on the eighth rising edge
    assign rx_push = (state == ENG_LOW) && tick && (bit_idx == 3'd7);
    assign rx_data = {rx_sh[6:0], miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            tmr      <= '0;
            half_q   <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            tot_q    <= '0;
            send_q   <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sck      <= 1'b0;
            cs_n     <= 1'b1;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        tot_q    <= total;
                        send_q   <= send;
                        half_q   <= half;
                        tmr      <= half;
                        bit_idx  <= '0;
                        byte_idx <= '0;
                        tx_sh    <= load_val;
                        cs_n     <= 1'b0;
                        state    <= ENG_LOW;
                    end
                end
                ENG_LOW: begin
                    if (tick) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                        tmr   <= half_q;
                        state <= ENG_HIGH;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ENG_HIGH: begin
                    if (tick) begin
                        sck <= 1'b0;
                        tmr <= half_q;
                        if (bit_idx != 3'd7) begin
                            bit_idx <= bit_idx + 1'b1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            state   <= ENG_LOW;
                        end else if (last_byte) begin
                            state <= ENG_TRAIL;
                        end else begin
                            bit_idx  <= '0;
                            byte_idx <= byte_idx + 1'b1;
                            tx_sh    <= load_val;
                            state    <= ENG_LOW;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ENG_TRAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        state <= ENG_IDLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int         FIFO_DEPTH = 64,
    parameter int         CNT_W      = 12,
    parameter int         HALF_W     = 8,
    parameter int         ADDR_W     = 3,
    parameter logic [7:0] FILL_BYTE  = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);

    logic              ctl_en, ctl_mst, ovf_q;
    logic [CNT_W-1:0]  total_q, send_q;
    logic [HALF_W-1:0] half_q;
    ctrl_req_t         creq;
    logic              ctrl_wr, go_req, tx_clr, rx_clr;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]        tx_dout;
    logic [LVL_W-1:0]  tx_level;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]        rx_din, rx_dout;
    logic [LVL_W-1:0]  rx_level;
    logic              eng_busy;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:11], reg_wdata[7:2], tx_full};

    assign creq    = decode_ctrl(reg_wdata);
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(RA_CTRL));
    assign tx_clr  = ctrl_wr && creq.tx_clr;
    assign rx_clr  = ctrl_wr && creq.rx_clr;
    assign go_req  = ctrl_wr && creq.go && creq.enable && creq.master
                     && (total_q != '0) && !eng_busy;
    assign tx_push = reg_wr && (reg_addr == ADDR_W'(RA_TXPSH));
    assign rx_pop  = reg_rd && (reg_addr == ADDR_W'(RA_RXPOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en  <= 1'b0;
            ctl_mst <= 1'b0;
            total_q <= '0;
            send_q  <= '0;
            half_q  <= HALF_W'(1);
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(RA_CTRL): begin
                    ctl_en  <= creq.enable;
                    ctl_mst <= creq.master;
                end
                ADDR_W'(RA_TOTAL): total_q <= reg_wdata[CNT_W-1:0];
                ADDR_W'(RA_SEND):  send_q  <= reg_wdata[CNT_W-1:0];
                ADDR_W'(RA_HALF):  half_q  <= reg_wdata[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    // sticky drop flag, cleared only with the receive queue
    always_ff @(posedge clk) begin
        if (rst || rx_clr) begin
            ovf_q <= 1'b0;
        end else if (rx_push && rx_full) begin
            ovf_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_CTRL): begin
                reg_rdata[CTL_EN]  = ctl_en;
                reg_rdata[CTL_MST] = ctl_mst;
                reg_rdata[CTL_GO]  = eng_busy;
            end
            ADDR_W'(RA_TOTAL): reg_rdata[CNT_W-1:0] = total_q;
            ADDR_W'(RA_SEND):  reg_rdata[CNT_W-1:0] = send_q;
            ADDR_W'(RA_STAT): begin
                reg_rdata[STS_RXLVL +: LVL_W] = rx_level;
                reg_rdata[STS_TXLVL +: LVL_W] = tx_level;
                reg_rdata[STS_OVF]            = ovf_q;
                reg_rdata[STS_BUSY]           = eng_busy;
            end
            ADDR_W'(RA_RXPOP): reg_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
            ADDR_W'(RA_HALF):  reg_rdata[HALF_W-1:0] = half_q;
            default: ;
        endcase
    end

    spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    spi_xfer_engine #(.CNT_W(CNT_W), .HALF_W(HALF_W), .FILL(FILL_BYTE)) u_eng (
        .clk(clk), .rst(rst), .start(go_req),
        .total(total_q), .send(send_q), .half(half_q),
        .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_din),
        .busy(eng_busy),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );
endmodule

// File: rtl/spi_burst_checks.sv
module spi_burst_checks #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             sck,
    input logic             mosi,
    input logic [LVL_W-1:0] rx_level,
    input logic             ovf,
    input logic             rx_clr,
    input logic             busy
);
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck); // R11

    AST_CS_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (!sck && !$past(sck))); // R11

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi)); // R9

    AST_RX_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_level) <= DEPTH)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !rx_clr) |=> ovf); // R8

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n); // R4
endmodule

bind spi_burst_master spi_burst_checks #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .rx_level(rx_level), .ovf(ovf_q), .rx_clr(rx_clr), .busy(eng_busy)
);

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int total_chk = 0, bad_chk = 0, cyc = 0;
    logic finished = 1'b0;

    spi_burst_master u_spi_burst_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- slave model and edge monitor ----------------
    logic [7:0] salt = 8'h00;
    logic [7:0] cap [128];
    int sl_bits = 0, n_rise = 0, n_csfall = 0;
    int t_csfall = 0, t_rise0 = 0, t_rise1 = 0, t_lastfall = 0, t_csrise = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0;

    function automatic logic [7:0] resp(input int k, input logic [7:0] s);
        return (8'(k) * 8'd29 + s) ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        if (prev_cs && !spi_cs_n) begin
            sl_bits  = 0;
            n_rise   = 0;
            t_csfall = cyc;
            n_csfall = n_csfall + 1;
        end
        if (!prev_sck && spi_sck) begin
            cap[(sl_bits >> 3) & 127][7 - (sl_bits % 8)] = spi_mosi;
            if (n_rise == 0) t_rise0 = cyc;
            if (n_rise == 1) t_rise1 = cyc;
            n_rise = n_rise + 1;
        end
        if (prev_sck && !spi_sck) begin
            sl_bits    = sl_bits + 1;
            t_lastfall = cyc;
        end
        if (!prev_cs && spi_cs_n) t_csrise = cyc;
        prev_cs  = spi_cs_n;
        prev_sck = spi_sck;
        spi_miso = resp(sl_bits >> 3, salt)[7 - (sl_bits % 8)];
    end

    // ---------------- helpers ----------------
    task automatic check(input logic ok, input string req, input int act, input int exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic pop, output logic [31:0] d);
        @(negedge clk);
        reg_rd = pop; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd0, 1'b0, v);
            if (!v[10]) break;
        end
    endtask

    logic [7:0] tx_exp [64];

    task automatic run_burst(input int h, input int tot, input int snd, input int npush);
        logic [31:0] v;
        int popped, exp_rx, lim;
        wr(3'd6, 32'(h));
        wr(3'd1, 32'(tot));
        wr(3'd2, 32'(snd));
        wr(3'd0, 32'h0000_0303);
        for (int i = 0; i < npush; i++) begin
            tx_exp[i] = 8'($urandom);
            wr(3'd4, {24'h0, tx_exp[i]});
        end
        for (int i = 0; i < 128; i++) cap[i] = 8'h00;
        salt = 8'($urandom);
        wr(3'd0, 32'h0000_0403);
        rd(3'd0, 1'b0, v);
        check(v[10] == 1'b1, "R4 start bit reads 1 while running", int'(v[10]), 1);
        wait_idle();
        rd(3'd0, 1'b0, v);
        check(v[10] == 1'b0, "R4 start bit self-clears", int'(v[10]), 0);
        check(sl_bits == tot * 8, "R5 bits clocked in burst", sl_bits, tot * 8);
        for (int i = 0; i < tot; i++) begin
            logic [7:0] e;
            e = (i < snd && i < npush) ? tx_exp[i] : 8'h00;
            check(cap[i] == e, "R5 R9 byte seen by slave", int'(cap[i]), int'(e));
        end
        check(t_rise0 - t_csfall == h + 1, "R11 lead time", t_rise0 - t_csfall, h + 1);
        check(t_csrise - t_lastfall == h + 1, "R11 trail time", t_csrise - t_lastfall, h + 1);
        check(t_rise1 - t_rise0 == 2 * (h + 1), "R10 SCK period", t_rise1 - t_rise0, 2 * (h + 1));
        lim    = (snd < tot) ? snd : tot;
        popped = (npush < lim) ? npush : lim;
        exp_rx = (tot < 64) ? tot : 64;
        rd(3'd3, 1'b0, v);
        check(int'(v[14:8]) == npush - popped, "R7 R5 TX level after burst", int'(v[14:8]), npush - popped);
        check(int'(v[6:0]) == exp_rx, "R7 R6 RX level after burst", int'(v[6:0]), exp_rx);
        check(v[16] == (tot > 64), "R8 overflow flag", int'(v[16]), int'(tot > 64));
        for (int i = 0; i < exp_rx; i++) begin
            rd(3'd5, 1'b1, v);
            check(v[7:0] == resp(i, salt), "R6 RX byte order", int'(v[7:0]), int'(resp(i, salt)));
        end
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            bad_chk++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total_chk + 1, bad_chk);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v;
        int fall0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins after reset", int'({spi_cs_n, spi_sck}), 2);
        rd(3'd0, 1'b0, v);
        check(v == 32'h0, "R1 control after reset", int'(v), 0);
        rd(3'd3, 1'b0, v);
        check(v == 32'h0, "R1 status after reset", int'(v), 0);
        rd(3'd6, 1'b0, v);
        check(v == 32'h1, "R1 half-period default", int'(v), 1);

        // R2 control readback and queue clear
        wr(3'd0, 32'h0000_0303);
        rd(3'd0, 1'b0, v);
        check(v == 32'h3, "R2 control readback", int'(v), 3);
        wr(3'd4, 32'h11); wr(3'd4, 32'h22); wr(3'd4, 32'h33);
        rd(3'd3, 1'b0, v);
        check(int'(v[14:8]) == 3, "R2 R7 TX level after pushes", int'(v[14:8]), 3);
        wr(3'd0, 32'h0000_0103);
        rd(3'd3, 1'b0, v);
        check(int'(v[14:8]) == 0, "R2 TX clear empties queue", int'(v[14:8]), 0);

        // R3 ignored starts
        fall0 = n_csfall;
        wr(3'd1, 32'd4);
        wr(3'd0, 32'h0000_0402);
        repeat (20) @(negedge clk);
        rd(3'd0, 1'b0, v);
        check(n_csfall == fall0 && v[10] == 1'b0, "R3 start without enable ignored", n_csfall - fall0, 0);
        wr(3'd0, 32'h0000_0401);
        repeat (20) @(negedge clk);
        check(n_csfall == fall0, "R3 start without master ignored", n_csfall - fall0, 0);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'h0000_0403);
        repeat (20) @(negedge clk);
        rd(3'd0, 1'b0, v);
        check(n_csfall == fall0 && v[10] == 1'b0, "R3 start with zero total ignored", n_csfall - fall0, 0);

        // directed: command prefix plus payload, and queue shortfall
        run_burst(1, 12, 4, 4);
        run_burst(1, 6, 4, 2);
        run_burst(0, 3, 0, 0);

        // random bursts
        for (int k = 0; k < 8; k++) begin
            int h, t, s, p;
            h = $urandom % 4;
            t = 1 + $urandom % 24;
            s = $urandom % (t + 3);
            p = $urandom % (s + 2);
            run_burst(h, t, s, p);
        end

        // R8 overflow, then clear
        run_burst(0, 70, 4, 4);
        wr(3'd0, 32'h0000_0103);
        rd(3'd3, 1'b0, v);
        check(v[16] == 1'b1, "R8 flag survives TX clear", int'(v[16]), 1);
        wr(3'd0, 32'h0000_0203);
        rd(3'd3, 1'b0, v);
        check(v[16] == 1'b0 && v[6:0] == 7'd0, "R8 RX clear drops flag", int'(v[16]), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end
endmodule